// File: doc/BRIEF.md
# Vector Instruction Expansion Sequencer

This block takes one decoded three-register arithmetic instruction and replays it as a run of scalar micro-operations. Each register number carries a one-bit vector tag. When any operand of the instruction is tagged, the block emits one micro-operation per element, up to the programmed length. In every micro-operation a tagged register number is advanced by the element index and an untagged one is repeated unchanged. The micro-operations enter a small in-order queue, and a downstream consumer drains that queue through a valid/ready stream.

Every micro-operation carries three things the consumer needs to tie results back to their source: its element index, an end-of-instruction flag, and a short instruction identifier. The consumer may report an exception on an element it has taken, giving that element's identifier and index. The block then drops every queued element of that instruction with a higher index. If it is still expanding the instruction, it stops and releases it to the upstream side. One cycle later it announces an abort carrying the same identifier and index.

The length register is loaded by a length-setting command, and the tag table is loaded one register at a time. Both are read while an instruction is expanded, so they must not change while `in_valid` is high.

Top module: `vec_expander`

## Requirements
- R1: For a tagged operand, element i carries register number (base + i) mod 32.
- R2: An untagged operand keeps its register number in every element of the instruction.
- R3: With a length L of 1 to 8 and at least one operand tagged, exactly L micro-operations are emitted, with element indices 0 to L-1 in order.
- R4: With a length of 0, or with no operand tagged, exactly one micro-operation is emitted with the instruction unchanged, element index 0 and the end flag set.
- R5: A length write above 8 stores 8, and a write from 0 to 8 stores the value as written.
- R6: The element index increases by one between consecutive micro-operations of an instruction. The end flag is 1 only on the final element, and the next instruction starts again at index 0.
- R7: `in_ready` is high only while `in_valid` is high. It is high in the cycle the final element enters the queue, or in the cycle a cancel releases the instruction, and in no other cycle.
- R8: The queue holds DEPTH entries. While it is full, expansion stalls with no element lost. While `out_valid` is high and `out_ready` is low, the presented micro-operation holds steady.
- R9: An exception report with identifier d and index k removes every queued element of instruction d whose index is above k. No element of d with an index above k is produced afterwards. `out_valid` is low in the cycle of the report.
- R10: The cycle after an exception report, `abort_valid` is high for one cycle and `abort_elem`/`abort_id` hold k and d.
- R11: After reset `out_valid` and `abort_valid` are low, the length register is 0 and every tag is clear.
- R12: The identifier starts at 0 after reset and increases by one, modulo 2^(log2(DEPTH)+1), for each instruction released upstream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| len_we | input | 1 | Load the length register |
| len_val | input | 4 | Requested length, clamped to 8 |
| tag_we | input | 1 | Write one vector tag |
| tag_reg | input | 5 | Register whose tag is written |
| tag_val | input | 1 | New tag value, 1 = vector |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Instruction released |
| in_op | input | 7 | Operation code, passed through |
| in_rd | input | 5 | Destination register |
| in_rs1 | input | 5 | First source register |
| in_rs2 | input | 5 | Second source register |
| out_valid | output | 1 | Micro-operation present |
| out_ready | input | 1 | Consumer takes the micro-operation |
| out_op | output | 7 | Operation code |
| out_rd | output | 5 | Stepped destination |
| out_rs1 | output | 5 | Stepped first source |
| out_rs2 | output | 5 | Stepped second source |
| out_elem | output | 3 | Element index |
| out_last | output | 1 | Final element of the instruction |
| out_id | output | 3 | Instruction identifier |
| exc_valid | input | 1 | Exception report on a taken element |
| exc_elem | input | 3 | Faulting element index |
| exc_id | input | 3 | Faulting instruction identifier |
| abort_valid | output | 1 | Abort notice |
| abort_elem | output | 3 | Index of the faulting element |
| abort_id | output | 3 | Identifier of the aborted instruction |

## Verification
The hardest situation to reach is an exception on an element while later elements of the same instruction sit in the queue and the expander is still producing that instruction. Only then do flush and cancel act in the same cycle. The stimulus reaches it by using lengths longer than the queue and throttling `out_ready` at random. Exceptions are raised at random on elements just taken, so many reports land while the instruction is partly queued and partly still to be generated. The bench then drops the remaining elements of that instruction from its expected stream and checks that none of them appears.

// File: rtl/vec_expander.sv
module vec_expander #(
  parameter int OP_W   = 7,
  parameter int REG_W  = 5,
  parameter int MAX_VL = 8,
  parameter int DEPTH  = 4
)(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        len_we,
  input  logic [$clog2(MAX_VL+1)-1:0] len_val,
  input  logic                        tag_we,
  input  logic [REG_W-1:0]            tag_reg,
  input  logic                        tag_val,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [OP_W-1:0]             in_op,
  input  logic [REG_W-1:0]            in_rd,
  input  logic [REG_W-1:0]            in_rs1,
  input  logic [REG_W-1:0]            in_rs2,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [OP_W-1:0]             out_op,
  output logic [REG_W-1:0]            out_rd,
  output logic [REG_W-1:0]            out_rs1,
  output logic [REG_W-1:0]            out_rs2,
  output logic [$clog2(MAX_VL)-1:0]   out_elem,
  output logic                        out_last,
  output logic [$clog2(DEPTH):0]      out_id,
  input  logic                        exc_valid,
  input  logic [$clog2(MAX_VL)-1:0]   exc_elem,
  input  logic [$clog2(DEPTH):0]      exc_id,
  output logic                        abort_valid,
  output logic [$clog2(MAX_VL)-1:0]   abort_elem,
  output logic [$clog2(DEPTH):0]      abort_id
);
  localparam int NREG = 1 << REG_W;
  localparam int LW   = $clog2(MAX_VL+1);
  localparam int EW   = $clog2(MAX_VL);
  localparam int PW   = $clog2(DEPTH);
  localparam int IW   = PW + 1;

  logic [NREG-1:0] vtag;
  logic [LW-1:0]   vlen;
  logic [EW-1:0]   elem_q;
  logic [IW-1:0]   gen_id;

  logic [OP_W-1:0]  f_op   [DEPTH];
  logic [REG_W-1:0] f_rd   [DEPTH];
  logic [REG_W-1:0] f_rs1  [DEPTH];
  logic [REG_W-1:0] f_rs2  [DEPTH];
  logic [EW-1:0]    f_elem [DEPTH];
  logic [IW-1:0]    f_id   [DEPTH];
  logic             f_last [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr, scan_idx;
  logic [IW-1:0]    cnt, fl;

  logic          any_vec, is_last, full, cancel, push, pop;
  logic [LW-1:0] n_elem, n_m1;

  assign any_vec = vtag[in_rd] | vtag[in_rs1] | vtag[in_rs2];
  assign n_elem  = (vlen == '0 || !any_vec) ? LW'(1) : vlen;
  assign n_m1    = n_elem - LW'(1);
  assign is_last = (LW'(elem_q) == n_m1);
  assign full    = (cnt == IW'(DEPTH));
  assign cancel  = in_valid && exc_valid && (exc_id == gen_id) && (elem_q != '0);
  assign push    = in_valid && !full && !cancel;
  assign in_ready = (push && is_last) || cancel;

  assign out_valid = (cnt != '0) && !exc_valid;
  assign pop       = out_valid && out_ready;
  assign out_op    = f_op[rd_ptr];
  assign out_rd    = f_rd[rd_ptr];
  assign out_rs1   = f_rs1[rd_ptr];
  assign out_rs2   = f_rs2[rd_ptr];
  assign out_elem  = f_elem[rd_ptr];
  assign out_last  = f_last[rd_ptr];
  assign out_id    = f_id[rd_ptr];

  always_comb begin
    fl = '0;
    scan_idx = rd_ptr;
    for (int i = 0; i < DEPTH; i++) begin
      scan_idx = rd_ptr + PW'(i);
      if (exc_valid && (IW'(i) < cnt) && (f_id[scan_idx] == exc_id) &&
          (f_elem[scan_idx] > exc_elem))
        fl = fl + IW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      f_op[wr_ptr]   <= in_op;
      f_rd[wr_ptr]   <= in_rd  + (vtag[in_rd]  ? REG_W'(elem_q) : '0);
      f_rs1[wr_ptr]  <= in_rs1 + (vtag[in_rs1] ? REG_W'(elem_q) : '0);
      f_rs2[wr_ptr]  <= in_rs2 + (vtag[in_rs2] ? REG_W'(elem_q) : '0);
      f_elem[wr_ptr] <= elem_q;
      f_id[wr_ptr]   <= gen_id;
      f_last[wr_ptr] <= is_last;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vtag        <= '0;
      vlen        <= '0;
      elem_q      <= '0;
      gen_id      <= '0;
      wr_ptr      <= '0;
      rd_ptr      <= '0;
      cnt         <= '0;
      abort_valid <= 1'b0;
      abort_elem  <= '0;
      abort_id    <= '0;
    end else begin
      if (tag_we) vtag[tag_reg] <= tag_val;
      if (len_we) vlen <= (int'(len_val) > MAX_VL) ? LW'(MAX_VL) : len_val;
      if (in_ready) begin
        elem_q <= '0;
        gen_id <= gen_id + IW'(1);
      end else if (push) begin
        elem_q <= elem_q + EW'(1);
      end
      if (push) wr_ptr <= wr_ptr + PW'(1);
      rd_ptr <= rd_ptr + PW'(pop) + fl[PW-1:0];
      cnt    <= cnt + IW'(push) - IW'(pop) - fl;
      abort_valid <= exc_valid;
      if (exc_valid) begin
        abort_elem <= exc_elem;
        abort_id   <= exc_id;
      end
    end
  end
endmodule

// File: rtl/vec_expander_chk.sv
module vec_expander_chk #(
  parameter int OP_W   = 7,
  parameter int REG_W  = 5,
  parameter int MAX_VL = 8,
  parameter int DEPTH  = 4
)(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic                      in_ready,
  input logic                      out_valid,
  input logic                      out_ready,
  input logic [OP_W-1:0]           out_op,
  input logic [REG_W-1:0]          out_rd,
  input logic [REG_W-1:0]          out_rs1,
  input logic [REG_W-1:0]          out_rs2,
  input logic [$clog2(MAX_VL)-1:0] out_elem,
  input logic                      out_last,
  input logic [$clog2(DEPTH):0]    out_id,
  input logic                      exc_valid,
  input logic [$clog2(MAX_VL)-1:0] exc_elem,
  input logic [$clog2(DEPTH):0]    exc_id,
  input logic                      abort_valid,
  input logic [$clog2(MAX_VL)-1:0] abort_elem,
  input logic [$clog2(DEPTH):0]    abort_id
);
  localparam int EW = $clog2(MAX_VL);
  localparam int IW = $clog2(DEPTH) + 1;

  logic          hs, seen, p_last;
  logic [EW-1:0] p_elem;
  logic [IW-1:0] p_id;

  assign hs = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen   <= 1'b0;
      p_last <= 1'b0;
      p_elem <= '0;
      p_id   <= '0;
    end else if (hs) begin
      seen   <= 1'b1;
      p_last <= out_last;
      p_elem <= out_elem;
      p_id   <= out_id;
    end
  end

  p_ready_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> in_valid);

  p_hold_when_stalled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !exc_valid) |=>
      (exc_valid || (out_valid && $stable(out_op) && $stable(out_rd) &&
       $stable(out_rs1) && $stable(out_rs2) && $stable(out_elem) &&
       $stable(out_last) && $stable(out_id))));

  p_elem_steps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && seen && !p_last && out_id == p_id) |-> (out_elem == EW'(p_elem + EW'(1))));

  p_restart_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && seen && p_last) |-> (out_elem == '0));

  p_id_advances_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && seen && p_last) |-> (out_id == IW'(p_id + IW'(1))));

  p_abort_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (abort_valid && abort_elem == $past(exc_elem) && abort_id == $past(exc_id)));

  p_abort_has_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_valid |-> $past(exc_valid));

  p_quiet_in_report_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> !hs);
endmodule

bind vec_expander vec_expander_chk #(
  .OP_W(OP_W), .REG_W(REG_W), .MAX_VL(MAX_VL), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op),
  .out_rd(out_rd), .out_rs1(out_rs1), .out_rs2(out_rs2),
  .out_elem(out_elem), .out_last(out_last), .out_id(out_id),
  .exc_valid(exc_valid), .exc_elem(exc_elem), .exc_id(exc_id),
  .abort_valid(abort_valid), .abort_elem(abort_elem), .abort_id(abort_id)
);

// File: tb/vec_expander_bench.sv
module vec_expander_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       last;
    logic [2:0] id;
    logic [2:0] elem;
    logic [4:0] rs2;
    logic [4:0] rs1;
    logic [4:0] rd;
    logic [6:0] op;
  } uop_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic len_we = 0, tag_we = 0, tag_val = 0, in_valid = 0, out_ready = 0, exc_valid = 0;
  logic [3:0] len_val = 0;
  logic [4:0] tag_reg = 0, in_rd = 0, in_rs1 = 0, in_rs2 = 0;
  logic [6:0] in_op = 0;
  logic [2:0] exc_elem = 0, exc_id = 0;
  logic in_ready, out_valid, out_last, abort_valid;
  logic [6:0] out_op;
  logic [4:0] out_rd, out_rs1, out_rs2;
  logic [2:0] out_elem, out_id, abort_elem, abort_id;

  vec_expander u_vec_expander (
    .clk(clk), .rst_n(rst_n), .len_we(len_we), .len_val(len_val),
    .tag_we(tag_we), .tag_reg(tag_reg), .tag_val(tag_val),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2),
    .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op),
    .out_rd(out_rd), .out_rs1(out_rs1), .out_rs2(out_rs2),
    .out_elem(out_elem), .out_last(out_last), .out_id(out_id),
    .exc_valid(exc_valid), .exc_elem(exc_elem), .exc_id(exc_id),
    .abort_valid(abort_valid), .abort_elem(abort_elem), .abort_id(abort_id)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, got = 0, ready_pct = 100, exc_pct = 0;
  logic [31:0] btag = '0;
  int bvl = 0;
  logic [2:0] next_id = 0;
  logic busy = 0, finished = 0;
  uop_t expq[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic set_len(input int v);
    len_we = 1; len_val = 4'(v);
    @(negedge clk); len_we = 0;
    bvl = (v > 8) ? 8 : v;
  endtask

  task automatic set_tag(input int r, input bit v);
    tag_we = 1; tag_reg = 5'(r); tag_val = v;
    @(negedge clk); tag_we = 0;
    btag[r] = v;
  endtask

  task automatic send(input int op, input int rd, input int rs1, input int rs2);
    uop_t u;
    int n;
    busy = 1;
    n = (bvl == 0 || !(btag[rd] | btag[rs1] | btag[rs2])) ? 1 : bvl;
    for (int e = 0; e < n; e++) begin
      u.op = 7'(op); u.elem = 3'(e); u.id = next_id; u.last = (e == n-1);
      u.rd  = btag[rd]  ? 5'(rd + e)  : 5'(rd);
      u.rs1 = btag[rs1] ? 5'(rs1 + e) : 5'(rs1);
      u.rs2 = btag[rs2] ? 5'(rs2 + e) : 5'(rs2);
      expq.push_back(u);
    end
    in_valid = 1; in_op = 7'(op); in_rd = 5'(rd); in_rs1 = 5'(rs1); in_rs2 = 5'(rs2);
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    next_id = next_id + 3'd1;
    @(negedge clk);
    in_valid = 0;
    busy = 0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((expq.size() != 0 || busy) && guard < 2000) begin @(negedge clk); guard++; end
    check(expq.size() == 0, "R3", "expected elements left undelivered", expq.size(), 0);
    @(negedge clk);
  endtask

  // consumer
  initial begin
    bit exc_pend = 0, abort_chk = 0;
    uop_t last_taken, e;
    logic [2:0] flushed_id = 0;
    bit flushed_ok = 0;
    forever begin
      @(negedge clk);
      if (exc_pend) begin
        exc_pend = 0;
        out_ready = 0;
        exc_valid = 1; exc_id = last_taken.id; exc_elem = last_taken.elem;
        while (expq.size() != 0 && expq[0].id == last_taken.id) void'(expq.pop_front());
        flushed_id = last_taken.id; flushed_ok = 1;
        abort_chk = 1;
        #1;
        check(!out_valid, "R9", "out_valid during report", int'(out_valid), 0);
      end else begin
        exc_valid = 0;
        out_ready = (int'($urandom % 100) < ready_pct);
        #1;
        if (abort_chk) begin
          abort_chk = 0;
          check(abort_valid && abort_elem == last_taken.elem && abort_id == last_taken.id,
                "R10", "abort notice", {abort_valid, abort_id, abort_elem},
                {1'b1, last_taken.id, last_taken.elem});
        end else begin
          check(!abort_valid, "R10", "abort without report", int'(abort_valid), 0);
        end
        if (out_valid && out_ready) begin
          got++;
          if (expq.size() == 0) begin
            check(0, "R3", "unexpected micro-operation elem", int'(out_elem), -1);
          end else begin
            e = expq.pop_front();
            check({out_rd, out_rs1, out_rs2} == {e.rd, e.rs1, e.rs2}, "R1 R2",
                  "register fields", {out_rd, out_rs1, out_rs2}, {e.rd, e.rs1, e.rs2});
            check({out_op, out_elem, out_last} == {e.op, e.elem, e.last}, "R6",
                  "op/elem/last", {out_op, out_elem, out_last}, {e.op, e.elem, e.last});
            check(out_id == e.id, "R12", "identifier", int'(out_id), int'(e.id));
            if (flushed_ok && out_id == flushed_id)
              check(out_elem <= last_taken.elem, "R9", "flushed element delivered",
                    int'(out_elem), int'(last_taken.elem));
            if (out_id != flushed_id) flushed_ok = 0;
            last_taken.id = out_id; last_taken.elem = out_elem;
            if (int'($urandom % 100) < exc_pct) exc_pend = 1;
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int c0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid, "R11", "out_valid in reset", int'(out_valid), 0);
    check(!abort_valid, "R11", "abort_valid in reset", int'(abort_valid), 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);

    // R11: length resets to 0, so a tagged instruction still emits one element
    set_tag(4, 1);
    c0 = got; send(5, 2, 4, 4); drain();
    check(got - c0 == 1, "R11", "elements with reset length", got - c0, 1);

    // R3: three-element example, r2 fixed, r4 stepped
    set_len(3);
    c0 = got; send(51, 2, 4, 4); drain();
    check(got - c0 == 3, "R3", "element count length 3", got - c0, 3);

    // R4: no tagged operand
    c0 = got; send(19, 7, 8, 9); drain();
    check(got - c0 == 1, "R4", "untagged element count", got - c0, 1);

    // R4: length 0
    set_len(0);
    c0 = got; send(19, 4, 4, 4); drain();
    check(got - c0 == 1, "R4", "zero-length element count", got - c0, 1);

    // R5: clamp above maximum
    set_len(13);
    c0 = got; send(33, 4, 1, 4); drain();
    check(got - c0 == 8, "R5", "clamped element count", got - c0, 8);

    // R1: wrap modulo 32
    set_len(4); set_tag(30, 1);
    c0 = got; send(3, 30, 30, 0); drain();
    check(got - c0 == 4, "R1", "wrap element count", got - c0, 4);

    // R7 R8: stall with a full queue
    set_len(8); set_tag(1, 1);
    ready_pct = 0;
    fork send(12, 1, 1, 2); join_none
    repeat (12) @(negedge clk);
    #1;
    check(!in_ready, "R7", "in_ready while queue full", int'(in_ready), 0);
    check(out_valid && out_elem == 0, "R8", "head held while stalled",
          {out_valid, out_elem}, {1'b1, 3'd0});
    ready_pct = 100;
    drain();

    // random phase with exceptions and backpressure
    ready_pct = 60; exc_pct = 12;
    for (int n = 0; n < 300; n++) begin
      if ($urandom % 5 == 0) set_len(int'($urandom % 16));
      if ($urandom % 3 == 0) set_tag(int'($urandom % 32), 1'($urandom % 2));
      send(int'($urandom % 128), int'($urandom % 32), int'($urandom % 32), int'($urandom % 32));
    end
    exc_pct = 0; ready_pct = 100;
    repeat (4) @(negedge clk);
    drain();
    finish_run();
  end
endmodule